// File: doc/BRIEF.md
# ADC Power Sequencer

This block is the host side of a link to a serial sampling converter whose frame is sixteen serial clocks long. It drives the active-low chip select and the serial clock, shifts in the returned data, and turns four commands into frames: one conversion, a burst of conversions, a move into the converter's low-power state, and a wake-up. The converter changes mode according to how many clock falling edges occur before chip select is released. A power-down frame is therefore deliberately cut short. A wake-up frame runs far enough to count as a dummy conversion, and its data is thrown away.

The controller keeps its own belief of whether the converter is asleep. It keeps chip select high for a fixed quiet interval between frames. After the start of a wake-up frame it also holds off the next frame until a minimum power-up time has passed. After reset it first sends a dummy frame that puts the converter into the mode chosen at build time, because the converter's mode after power-on is unknown. The serial clock half-period, the cut points, the quiet time and the power-up time are all parameters.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is held, `cs_n` and `sclk` are high, `busy` is high, and `rd_valid` and `cmd_err` are low. The first clock after reset starts one dummy frame without any command: a power-down frame when `INIT_DOWN` is 1, a wake frame when it is 0. Commands are accepted only after that frame and its gap.
- R2: A conversion (`cmd_op` 0) holds `cs_n` low for 2·DIV·FRAME_BITS clocks. `sclk` starts high, toggles every DIV clocks and gives FRAME_BITS falling edges. `cs_n` and `sclk` both return high on the same clock.
- R3: `sdata` is sampled on every `sclk` falling edge, first bit as MSB. At the clock where `cs_n` rises after a conversion, `rd_data` takes the FRAME_BITS-bit word and `rd_valid` is high for exactly one clock.
- R4: A power-down request (`cmd_op` 2) releases `cs_n` at the `sclk` rising point after falling edge PD_CUT, where 2 ≤ PD_CUT ≤ 9. It gives no `rd_valid` and sets `pd_state` to 1 on that clock.
- R5: A wake request (`cmd_op` 3) runs a frame of WAKE_CUT falling edges, where 10 ≤ WAKE_CUT ≤ FRAME_BITS. Its data is discarded (no `rd_valid`) and `pd_state` is cleared when the frame ends.
- R6: Between two frames `cs_n` stays high for QUIET_CYC clocks when nothing else delays the next frame.
- R7: A frame cannot start earlier than PWRUP_CYC clocks after the clock on which the wake frame pulled `cs_n` low. If the wake frame plus the quiet time is shorter than that, `busy` stays high until the power-up time has run out.
- R8: A burst (`cmd_op` 1) with `burst_len` N runs N conversions, each with its own `rd_valid` strobe and a quiet gap between them. A `burst_len` of 0 runs one conversion.
- R9: `busy` is high from the clock a command is accepted until its last gap ends. Commands presented while `busy` is high are ignored.
- R10: A conversion or burst request while `pd_state` is 1 starts no frame. Instead it gives a one-clock `cmd_err` pulse and `busy` stays low.
- R11: A command accepted while idle pulls `cs_n` low on the same clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this clock |
| cmd_op | input | 2 | 0 convert, 1 burst, 2 power down, 3 wake |
| burst_len | input | BURST_W | Number of conversions in a burst |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame, gap or start-up frame in progress |
| pd_state | output | 1 | Believed converter state, 1 = powered down |
| rd_data | output | FRAME_BITS | Last conversion word |
| rd_valid | output | 1 | One-clock strobe for a new `rd_data` |
| cmd_err | output | 1 | One-clock pulse for a refused conversion |

## Verification
The bench sends a power-down command in the middle of a conversion. A design that does not ignore it would cut the frame short or flip `pd_state`. The wake frame is built shorter than the power-up time, and a conversion is held pending behind it. A design that honoured only the quiet time would pull `cs_n` low too early, and the bench checks the spacing between the two chip-select falls directly. Bursts of three and of zero catch off-by-one counting of the remaining conversions and gaps that are a clock short. Requests made while powered down must produce an error pulse and no frame, not a silent conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      OP_CONV  = 2'd0,
      OP_BURST = 2'd1,
      OP_SLEEP = 2'd2,
      OP_WAKE  = 2'd3
   } seq_op_e;

   typedef enum logic [1:0] {
      FK_CONV  = 2'd0,
      FK_SLEEP = 2'd1,
      FK_WAKE  = 2'd2
   } frame_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/adc_sclk_gen.sv
// Serial clock generator: sclk idles high, each half period lasts DIV clocks.
module adc_sclk_gen #(
   parameter int DIV        = 2,
   parameter int FRAME_BITS = 16,
   localparam int EW        = $clog2(FRAME_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          run,
   output logic          sclk,
   output logic          fall_tick,
   output logic          rise_tick,
   output logic [EW-1:0] fall_cnt
);

   logic half_tick;

   generate
      if (DIV == 1) begin : g_nodiv
         assign half_tick = run;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] div_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (start || !run) begin
               div_cnt <= '0;
            end else if (div_cnt == DW'(DIV - 1)) begin
               div_cnt <= '0;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end

         assign half_tick = run && (div_cnt == DW'(DIV - 1));
      end
   endgenerate

   assign fall_tick = half_tick && sclk;
   assign rise_tick = half_tick && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk     <= 1'b1;
         fall_cnt <= '0;
      end else if (start) begin
         sclk     <= 1'b1;
         fall_cnt <= '0;
      end else if (fall_tick) begin
         sclk     <= 1'b0;
         fall_cnt <= fall_cnt + 1'b1;
      end else if (rise_tick) begin
         sclk     <= 1'b1;
      end
   end

endmodule

// File: rtl/adc_rx_shift.sv
// Captures serial data MSB first and presents the word with a one-clock strobe.
module adc_rx_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sdata,
   input  logic         sample,
   input  logic         load,
   output logic [W-1:0] rd_data,
   output logic         rd_valid
);

   logic [W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (sample) begin
         sh <= {sh[W-2:0], sdata};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= load;
         if (load) begin
            rd_data <= sh;
         end
      end
   end

endmodule

// File: rtl/adc_seq_fsm.sv
// Frame sequencer: command decode, cut points, quiet gap, power-up hold-off.
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int FRAME_BITS = 16,
   parameter int PD_CUT     = 4,
   parameter int WAKE_CUT   = 16,
   parameter int QUIET_CYC  = 4,
   parameter int PWRUP_CYC  = 200,
   parameter int BURST_W    = 4,
   parameter bit INIT_DOWN  = 1'b0,
   localparam int EW        = $clog2(FRAME_BITS + 1),
   localparam int QW        = $clog2(QUIET_CYC + 1),
   localparam int PW        = $clog2(PWRUP_CYC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [BURST_W-1:0] burst_len,
   input  logic               rise_tick,
   input  logic [EW-1:0]      fall_cnt,
   output logic               start,
   output logic               run,
   output logic               cap,
   output logic               cs_n,
   output logic               busy,
   output logic               pd_state,
   output logic               cmd_err
);

   function automatic logic [EW-1:0] cut_of(frame_kind_e k);
      case (k)
         FK_SLEEP: return EW'(PD_CUT);
         FK_WAKE:  return EW'(WAKE_CUT);
         default:  return EW'(FRAME_BITS);
      endcase
   endfunction

   seq_state_e         state;
   frame_kind_e        kind, kind_n;
   seq_op_e            op;
   logic [EW-1:0]      cut;
   logic [QW-1:0]      quiet_cnt;
   logic [PW-1:0]      pu_cnt;
   logic [BURST_W-1:0] burst_left;
   logic               init_pend;
   logic               accept, refuse, frame_end, gap_done;

   assign op = seq_op_e'(cmd_op);

   always_comb begin
      accept    = (state == ST_IDLE) && !init_pend && cmd_valid;
      refuse    = accept && pd_state && ((op == OP_CONV) || (op == OP_BURST));
      frame_end = (state == ST_FRAME) && rise_tick && (fall_cnt == cut);
      gap_done  = (state == ST_GAP) && (quiet_cnt == '0) && (pu_cnt == '0);
      start     = 1'b0;
      kind_n    = FK_CONV;
      if ((state == ST_IDLE) && init_pend) begin
         start  = 1'b1;
         kind_n = INIT_DOWN ? FK_SLEEP : FK_WAKE;
      end else if (accept && !refuse) begin
         start = 1'b1;
         case (op)
            OP_SLEEP: kind_n = FK_SLEEP;
            OP_WAKE:  kind_n = FK_WAKE;
            default:  kind_n = FK_CONV;
         endcase
      end else if (gap_done && (burst_left != '0)) begin
         start  = 1'b1;
         kind_n = FK_CONV;
      end
   end

   assign run  = (state == ST_FRAME);
   assign cap  = frame_end && (kind == FK_CONV);
   assign busy = (state != ST_IDLE) || init_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= FK_CONV;
         cut       <= EW'(FRAME_BITS);
         init_pend <= 1'b1;
         cs_n      <= 1'b1;
      end else begin
         if (start) begin
            state     <= ST_FRAME;
            kind      <= kind_n;
            cut       <= cut_of(kind_n);
            init_pend <= 1'b0;
            cs_n      <= 1'b0;
         end else if (frame_end) begin
            state <= ST_GAP;
            cs_n  <= 1'b1;
         end else if (gap_done) begin
            state <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
      end else if (frame_end) begin
         quiet_cnt <= QW'(QUIET_CYC - 1);
      end else if ((state == ST_GAP) && (quiet_cnt != '0)) begin
         quiet_cnt <= quiet_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pu_cnt <= '0;
      end else if (start && (kind_n == FK_WAKE)) begin
         pu_cnt <= PW'(PWRUP_CYC - 1);
      end else if (pu_cnt != '0) begin
         pu_cnt <= pu_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_left <= '0;
      end else if (accept && !refuse && (op == OP_BURST)) begin
         burst_left <= (burst_len == '0) ? '0 : burst_len - 1'b1;
      end else if (accept && !refuse && (op == OP_CONV)) begin
         burst_left <= '0;
      end else if (gap_done && (burst_left != '0)) begin
         burst_left <= burst_left - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_state <= INIT_DOWN;
         cmd_err  <= 1'b0;
      end else begin
         cmd_err <= refuse;
         if (frame_end && (kind == FK_SLEEP)) begin
            pd_state <= 1'b1;
         end else if (frame_end && (kind == FK_WAKE)) begin
            pd_state <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
   parameter int DIV        = 2,
   parameter int FRAME_BITS = 16,
   parameter int PD_CUT     = 4,
   parameter int WAKE_CUT   = 16,
   parameter int QUIET_CYC  = 4,
   parameter int PWRUP_CYC  = 200,
   parameter int BURST_W    = 4,
   parameter bit INIT_DOWN  = 1'b0,
   localparam int EW        = $clog2(FRAME_BITS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [1:0]            cmd_op,
   input  logic [BURST_W-1:0]    burst_len,
   input  logic                  sdata,
   output logic                  cs_n,
   output logic                  sclk,
   output logic                  busy,
   output logic                  pd_state,
   output logic [FRAME_BITS-1:0] rd_data,
   output logic                  rd_valid,
   output logic                  cmd_err
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("DIV must be at least 1");
      end
      if (FRAME_BITS < 10) begin : g_bad_frame
         $error("FRAME_BITS must be at least 10");
      end
      if ((PD_CUT < 2) || (PD_CUT > 9)) begin : g_bad_pd
         $error("PD_CUT must lie in 2..9");
      end
      if ((WAKE_CUT < 10) || (WAKE_CUT > FRAME_BITS)) begin : g_bad_wake
         $error("WAKE_CUT must lie in 10..FRAME_BITS");
      end
      if ((QUIET_CYC < 1) || (PWRUP_CYC < 1) || (BURST_W < 1)) begin : g_bad_cnt
         $error("QUIET_CYC, PWRUP_CYC and BURST_W must be positive");
      end
   endgenerate

   logic          start, run, cap;
   logic          fall_tick, rise_tick;
   logic [EW-1:0] fall_cnt;

   adc_seq_fsm #(
      .FRAME_BITS (FRAME_BITS),
      .PD_CUT     (PD_CUT),
      .WAKE_CUT   (WAKE_CUT),
      .QUIET_CYC  (QUIET_CYC),
      .PWRUP_CYC  (PWRUP_CYC),
      .BURST_W    (BURST_W),
      .INIT_DOWN  (INIT_DOWN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .burst_len (burst_len),
      .rise_tick (rise_tick),
      .fall_cnt  (fall_cnt),
      .start     (start),
      .run       (run),
      .cap       (cap),
      .cs_n      (cs_n),
      .busy      (busy),
      .pd_state  (pd_state),
      .cmd_err   (cmd_err)
   );

   adc_sclk_gen #(
      .DIV        (DIV),
      .FRAME_BITS (FRAME_BITS)
   ) u_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .run       (run),
      .sclk      (sclk),
      .fall_tick (fall_tick),
      .rise_tick (rise_tick),
      .fall_cnt  (fall_cnt)
   );

   adc_rx_shift #(
      .W (FRAME_BITS)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sdata    (sdata),
      .sample   (fall_tick),
      .load     (cap),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
   parameter int QUIET_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic busy,
   input logic pd_state,
   input logic rd_valid,
   input logic cmd_err
);

   int   hi_cnt;
   logic seen_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt   <= 0;
         seen_low <= 1'b0;
      end else if (cs_n) begin
         if (hi_cnt < 1000000) hi_cnt <= hi_cnt + 1;
      end else begin
         hi_cnt   <= 0;
         seen_low <= 1'b1;
      end
   end

   assert_sclk_idles_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   assert_strobe_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_strobe_at_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(cs_n));

   assert_pd_moves_at_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state != $past(pd_state)) |-> $rose(cs_n));

   assert_quiet_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && seen_low) |-> (hi_cnt >= QUIET_CYC));

   assert_busy_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   assert_err_only_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> (pd_state && !busy && cs_n));

endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sclk     (sclk),
   .busy     (busy),
   .pd_state (pd_state),
   .rd_valid (rd_valid),
   .cmd_err  (cmd_err)
);

// File: tb/sim_adc_pwr_seq.sv
`timescale 1ns/100ps
module sim_adc_pwr_seq;

   localparam int DIV = 2;
   localparam int FB  = 16;
   localparam int PDC = 4;
   localparam int WKC = 10;
   localparam int Q   = 3;
   localparam int PW  = 60;
   localparam int BW  = 4;
   localparam bit IND = 1'b0;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic [1:0]    cmd_op;
   logic [BW-1:0] burst_len;
   logic          sdata = 1'b0;
   logic          cs_n, sclk, busy, pd_state, rd_valid, cmd_err;
   logic [FB-1:0] rd_data;

   always #2.5 clk = ~clk;

   adc_pwr_seq #(
      .DIV(DIV), .FRAME_BITS(FB), .PD_CUT(PDC), .WAKE_CUT(WKC),
      .QUIET_CYC(Q), .PWRUP_CYC(PW), .BURST_W(BW), .INIT_DOWN(IND)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .burst_len(burst_len), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
      .busy(busy), .pd_state(pd_state), .rd_data(rd_data),
      .rd_valid(rd_valid), .cmd_err(cmd_err)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   function automatic logic [15:0] word_of(int i);
      logic [7:0] b;
      b = i[7:0];
      return {b ^ 8'h5A, ~b ^ 8'h3C};
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Converter model: shifts a per-frame word out, next bit after each sclk fall.
   int adc_idx = -1;
   int adc_falls = 0;
   bit prev_cs = 1'b1, prev_sclk = 1'b1;
   always @(negedge clk) begin
      logic [15:0] w;
      if (prev_cs && !cs_n) begin
         adc_idx++;
         adc_falls = 0;
      end else if (!cs_n && prev_sclk && !sclk) begin
         adc_falls++;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
      w = word_of(adc_idx);
      sdata = (!cs_n && adc_falls < 16) ? w[15 - adc_falls] : 1'b0;
   end

   // Reference model, evaluated once per rising edge.
   int n = 0, f_start = 0, f_cut = 0, f_kind = 0, f_idx = -1;
   bit act = 0, gap = 0, init_p = 1;
   int gap_until = 0, quiet_end = 0, pu_ready = 0, burst_rem = 0;
   bit m_pd = IND, m_cs = 1, m_sclk = 1, m_busy = 1, m_valid = 0, m_err = 0;
   logic [15:0] m_data = '0;
   string m_tag = "R1";

   task automatic m_start(int kind);
      act = 1; f_start = n; f_kind = kind; f_idx++;
      f_cut = (kind == 0) ? FB : (kind == 1) ? PDC : WKC;
      if (kind == 2) pu_ready = n + PW;
   endtask

   always @(posedge clk) begin
      n++;
      m_valid = 0; m_err = 0;
      if (!rst_n) begin
         act = 0; gap = 0; init_p = 1; burst_rem = 0; pu_ready = 0;
         f_idx = -1; m_pd = IND;
      end else if (act) begin
         if (n - f_start == 2 * DIV * f_cut) begin
            act = 0; gap = 1;
            quiet_end = n + Q;
            gap_until = (quiet_end > pu_ready) ? quiet_end : pu_ready;
            if (f_kind == 0) begin m_valid = 1; m_data = word_of(f_idx); end
            else if (f_kind == 1) m_pd = 1;
            else m_pd = 0;
         end
      end else if (gap) begin
         if (n >= gap_until) begin
            gap = 0;
            if (burst_rem > 0) begin burst_rem--; m_start(0); end
         end
      end else if (init_p) begin
         init_p = 0;
         m_start(IND ? 1 : 2);
      end else if (cmd_valid) begin
         case (cmd_op)
            2'd0: if (m_pd) m_err = 1; else begin burst_rem = 0; m_start(0); end
            2'd1: if (m_pd) m_err = 1;
                  else begin burst_rem = (burst_len == 0) ? 0 : int'(burst_len) - 1; m_start(0); end
            2'd2: m_start(1);
            default: m_start(2);
         endcase
      end
      if (act) begin
         m_cs = 0;
         m_sclk = (((n - f_start) / DIV) % 2 == 0);
         m_tag = (f_kind == 0) ? "R2" : (f_kind == 1) ? "R4" : "R5";
      end else begin
         m_cs = 1; m_sclk = 1;
         m_tag = gap ? ((n >= quiet_end) ? "R7" : "R6") : "R11";
      end
      m_busy = act || gap || init_p;
   end

   // Cycle-by-cycle comparison plus port-level bookkeeping.
   int cyc = 0, vcount = 0, ecount = 0, hi_run = 0, lo_run = 0, lo_last = 0;
   int fall_q[$];
   int gap_q[$];
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         check(cs_n === m_cs, m_tag, "cs_n", cs_n, m_cs);
         check(sclk === m_sclk, m_tag, "sclk", sclk, m_sclk);
         check(busy === m_busy, "R9", "busy", busy, m_busy);
         check(pd_state === m_pd, "R4", "pd_state", pd_state, m_pd);
         check(rd_valid === m_valid, "R3", "rd_valid", rd_valid, m_valid);
         check(cmd_err === m_err, "R10", "cmd_err", cmd_err, m_err);
         if (m_valid)
            check(rd_data === m_data, "R3", "rd_data", rd_data, m_data);
         if (rd_valid) vcount++;
         if (cmd_err) ecount++;
         if (!cs_n) begin
            if (hi_run > 0 && prev_mon_cs) begin
               fall_q.push_back(cyc);
               gap_q.push_back(hi_run);
            end
            hi_run = 0; lo_run++;
         end else begin
            if (lo_run > 0) lo_last = lo_run;
            lo_run = 0; hi_run++;
         end
         prev_mon_cs = cs_n;
      end
   end
   bit prev_mon_cs = 1'b1;

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic send(int op, int len, bit expect_start, string tag);
      cmd_valid = 1'b1;
      cmd_op = op[1:0];
      burst_len = len[BW-1:0];
      @(negedge clk);
      cmd_valid = 1'b0;
      if (expect_start) check(cs_n == 1'b0, tag, "cs_n after accept", cs_n, 0);
      else check(cs_n == 1'b1, tag, "cs_n after refuse", cs_n, 1);
   endtask

   initial begin
      int v0, f0, e0, t0;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; burst_len = '0;
      repeat (4) @(negedge clk);
      check(cs_n && sclk && busy && !rd_valid && !cmd_err, "R1", "reset outputs",
            {cs_n, sclk, busy, rd_valid, cmd_err}, 5'b11100);
      rst_n = 1'b1;
      wait_idle();
      check(fall_q.size() == 1, "R1", "start-up frames", fall_q.size(), 1);
      check(pd_state == IND, "R1", "state after start-up", pd_state, IND);
      check(lo_last == 2 * DIV * WKC, "R1", "start-up frame length", lo_last, 2 * DIV * WKC);

      // single conversion, R11 and R2
      v0 = vcount;
      send(0, 0, 1, "R11");
      wait_idle();
      check(vcount - v0 == 1, "R3", "strobes", vcount - v0, 1);
      check(lo_last == 2 * DIV * FB, "R2", "frame length", lo_last, 2 * DIV * FB);
      check(rd_data == word_of(1), "R3", "captured word", rd_data, word_of(1));

      // power-down request during a conversion is ignored, R9
      f0 = fall_q.size();
      send(0, 0, 1, "R11");
      repeat (6) @(negedge clk);
      send(2, 0, 1, "R9");
      wait_idle();
      check(pd_state == 1'b0, "R9", "pd_state after ignored request", pd_state, 0);
      check(fall_q.size() - f0 == 1, "R9", "frames", fall_q.size() - f0, 1);
      check(lo_last == 2 * DIV * FB, "R9", "frame not cut", lo_last, 2 * DIV * FB);

      // burst of three, R8 and R6
      v0 = vcount;
      send(1, 3, 1, "R8");
      wait_idle();
      check(vcount - v0 == 3, "R8", "burst strobes", vcount - v0, 3);
      check(gap_q[gap_q.size() - 1] == Q, "R6", "burst gap", gap_q[gap_q.size() - 1], Q);
      check(gap_q[gap_q.size() - 2] == Q, "R6", "burst gap", gap_q[gap_q.size() - 2], Q);

      // burst length zero acts as one, R8
      v0 = vcount;
      send(1, 0, 1, "R8");
      wait_idle();
      check(vcount - v0 == 1, "R8", "zero-length burst strobes", vcount - v0, 1);

      // power down, R4
      v0 = vcount;
      send(2, 0, 1, "R4");
      wait_idle();
      check(pd_state == 1'b1, "R4", "pd_state", pd_state, 1);
      check(vcount == v0, "R4", "no strobe", vcount, v0);
      check(lo_last == 2 * DIV * PDC, "R4", "cut frame length", lo_last, 2 * DIV * PDC);

      // requests while asleep, R10
      f0 = fall_q.size(); e0 = ecount;
      send(0, 0, 0, "R10");
      check(cmd_err == 1'b1 && busy == 1'b0, "R10", "err pulse, idle", {cmd_err, busy}, 2'b10);
      @(negedge clk);
      send(1, 2, 0, "R10");
      repeat (3) @(negedge clk);
      check(ecount - e0 == 2, "R10", "error pulses", ecount - e0, 2);
      check(fall_q.size() == f0, "R10", "no frame", fall_q.size(), f0);

      // wake with a conversion held pending behind it, R5 and R7
      v0 = vcount; f0 = fall_q.size();
      send(3, 0, 1, "R5");
      cmd_valid = 1'b1; cmd_op = 2'd0;
      while (fall_q.size() < f0 + 2 && cyc < 20000) @(negedge clk);
      cmd_valid = 1'b0;
      check(vcount == v0, "R5", "wake data discarded", vcount, v0);
      check(pd_state == 1'b0, "R5", "pd_state after wake", pd_state, 0);
      t0 = fall_q[f0 + 1] - fall_q[f0];
      check(t0 == PW + 1, "R7", "wake-to-conversion spacing", t0, PW + 1);
      wait_idle();
      check(vcount - v0 == 1, "R7", "conversion after wake", vcount - v0, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule